// File: doc/BRIEF.md
# Byte-Serial Reflected CRC-16 Engine

This block keeps a 16-bit check register that is updated once for every byte offered on a valid strobe. A link controller uses it in two ways. When it sends a record, it reads out the check value that the block computed and appends it. When it receives a record, it runs the received bytes, check bytes included, through the block and looks at the residue.

Each byte is folded into the register in a particular order. The byte is first XORed into the upper eight bits. The register then takes eight right-shift steps, and a step XORs in the reflected constant 0xA001 whenever the bit shifted out was 1. A build parameter selects how the eight steps run. In one variant they take one step per cycle over eight cycles and a busy output covers them. In the other they all happen in one combinational stage. Both variants must give the same register value.

A small serialiser sends the current value out as two bytes on request.

Top module: `crc16_byte_engine`

## Requirements
- R1: After reset, or after a cycle with `clear` high, `crcOut` is 0x0000, `busy` is low and `residueZero` is high.
- R2: An accepted byte b changes the register from c to F(c XOR (b << 8)). F applies eight steps, and each step maps x to (x >> 1) XOR 0xA001 when x[0] is 1, and to x >> 1 otherwise.
- R3: With `SERIAL`=1, an accepted byte raises `busy` from the cycle after acceptance for exactly eight cycles. The new value of R2 is on `crcOut` in the first cycle where `busy` is low again.
- R4: With `SERIAL`=0, the R2 value is on `crcOut` in the cycle after acceptance and `busy` never rises. Both variants give identical values for the same byte stream.
- R5: A byte offered while `busy` is high is not accepted and leaves the register unchanged. `dropFlag` is high for the one cycle that follows the offer.
- R6: `clear` wins over `byteValid` in the same cycle. The register becomes 0, the byte is discarded and any step sequence in progress ends.
- R7: `residueZero` is high exactly when the register is 0x0000 and `busy` is low. It stays low during the step cycles even if the register passes through zero.
- R8: An `emitStart` accepted while idle captures the register. In the next cycle `emitValid` is high and `emitByte` carries bits 15:8 with `emitLast` low. In the cycle after that, `emitByte` carries bits 7:0 with `emitLast` high. `emitValid` then falls.
- R9: `emitStart` is ignored while `busy` is high or while a two-byte emission is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Zero the register before a record |
| byteValid | input | 1 | Strobe: `byteIn` holds a byte to fold in |
| byteIn | input | 8 | Data byte |
| emitStart | input | 1 | Request to emit the current value as two bytes |
| crcOut | output | 16 | Running register value |
| residueZero | output | 1 | Register is zero and idle |
| busy | output | 1 | Bit steps in progress (serial variant) |
| dropFlag | output | 1 | One-cycle pulse: a byte offered while busy was ignored |
| emitValid | output | 1 | `emitByte` is valid |
| emitByte | output | 8 | Emitted check byte, high half first |
| emitLast | output | 1 | Marks the second emitted byte |

## Verification
The embedded assertions check these rules on every cycle:
- the register holds its value when no strobe from the control is active;
- `clear` empties the register and ends the step sequence;
- an accepted byte raises `busy`;
- an offer made while busy raises `dropFlag`;
- the emitter puts out the captured high byte and then the low byte.

Only the bench scenarios can show that the register holds the right value after a byte. They do this by running the serial and combinational variants side by side against a bench model of the fold. The bench scenarios also cover the exact eight-cycle busy window, the residue flag staying low while a zero-valued register is still stepping, and emission requests refused during stepping.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic clrReg;    // zero the register
    logic loadByte;  // XOR the byte into the upper half (serial variant)
    logic foldByte;  // XOR the byte and apply all steps in one stage
    logic stepBit;   // apply one single-bit step
  } crcStrobes_t;

  typedef enum logic [1:0] {
    EMIT_IDLE = 2'd0,
    EMIT_HIGH = 2'd1,
    EMIT_LOW  = 2'd2
  } emitPhase_t;

endpackage

// File: rtl/crc16_ctrl.sv
module crc16_ctrl
  import crc16_pkg::*;
#(
  parameter int SERIAL = 1,
  parameter int STEPS  = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        clear,
  input  logic        byteValid,
  output crcStrobes_t strb,
  output logic        busy,
  output logic        dropFlag
);

  localparam int CW = $clog2(STEPS + 1);

  logic accept;

  assign accept = byteValid && !busy && !clear;

  generate
    if (SERIAL != 0) begin : g_serial
      logic [CW-1:0] stepCnt;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                stepCnt <= '0;
        else if (clear)           stepCnt <= '0;
        else if (accept)          stepCnt <= CW'(STEPS);
        else if (stepCnt != '0)   stepCnt <= stepCnt - 1'b1;
      end

      assign busy = (stepCnt != '0);

      always_comb begin
        strb          = '0;
        strb.clrReg   = clear;
        strb.loadByte = accept;
        strb.stepBit  = busy && !clear;
      end

      // R3
      accept_raises_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
        (byteValid && !busy && !clear) |=> busy);
    end else begin : g_parallel
      assign busy = 1'b0;

      always_comb begin
        strb          = '0;
        strb.clrReg   = clear;
        strb.foldByte = accept;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dropFlag <= 1'b0;
    else       dropFlag <= byteValid && busy && !clear;
  end

  // R5
  drop_flagged_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && busy && !clear) |=> dropFlag);

  // R6
  clear_ends_steps_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> !busy);

endmodule

// File: rtl/crc16_datapath.sv
module crc16_datapath
  import crc16_pkg::*;
#(
  parameter int          CRC_W  = 16,
  parameter int          BYTE_W = 8,
  parameter logic [15:0] POLY   = 16'hA001
) (
  input  logic              clk,
  input  logic              rstN,
  input  crcStrobes_t       strb,
  input  logic              busy,
  input  logic [BYTE_W-1:0] byteIn,
  output logic [CRC_W-1:0]  crcReg,
  output logic              residueZero
);

  localparam int SH = CRC_W - BYTE_W;
  localparam logic [CRC_W-1:0] POLY_W = CRC_W'(POLY);

  function automatic logic [CRC_W-1:0] stepOne(input logic [CRC_W-1:0] c);
    return c[0] ? ((c >> 1) ^ POLY_W) : (c >> 1);
  endfunction

  function automatic logic [CRC_W-1:0] foldAll(input logic [CRC_W-1:0] c);
    logic [CRC_W-1:0] t;
    t = c;
    for (int i = 0; i < BYTE_W; i++) t = stepOne(t);
    return t;
  endfunction

  logic [CRC_W-1:0] mixed;

  assign mixed = crcReg ^ (CRC_W'(byteIn) << SH);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              crcReg <= '0;
    else if (strb.clrReg)   crcReg <= '0;
    else if (strb.foldByte) crcReg <= foldAll(mixed);
    else if (strb.loadByte) crcReg <= mixed;
    else if (strb.stepBit)  crcReg <= stepOne(crcReg);
  end

  assign residueZero = (crcReg == '0) && !busy;

  // R2
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.clrReg || strb.foldByte || strb.loadByte || strb.stepBit) |=> $stable(crcReg));

  // R6
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrReg |=> (crcReg == '0));

endmodule

// File: rtl/crc16_emitter.sv
module crc16_emitter
  import crc16_pkg::*;
#(
  parameter int CRC_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              emitStart,
  input  logic              busy,
  input  logic [CRC_W-1:0]  value,
  output logic              emitValid,
  output logic [BYTE_W-1:0] emitByte,
  output logic              emitLast
);

  emitPhase_t       phase;
  logic [CRC_W-1:0] held;
  logic             take;

  assign take = emitStart && !busy && (phase == EMIT_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= EMIT_IDLE;
      held  <= '0;
    end else begin
      case (phase)
        EMIT_IDLE: if (take) begin
                     phase <= EMIT_HIGH;
                     held  <= value;
                   end
        EMIT_HIGH: phase <= EMIT_LOW;
        default:   phase <= EMIT_IDLE;
      endcase
    end
  end

  assign emitValid = (phase != EMIT_IDLE);
  assign emitLast  = (phase == EMIT_LOW);
  assign emitByte  = (phase == EMIT_HIGH) ? held[CRC_W-1 -: BYTE_W] : held[BYTE_W-1:0];

  // R8
  emit_high_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (emitStart && !busy && !emitValid) |=>
      (emitValid && !emitLast && emitByte == $past(value[CRC_W-1 -: BYTE_W])));

  // R8
  emit_low_second_chk: assert property (@(posedge clk) disable iff (!rstN)
    (emitValid && !emitLast) |=> (emitValid && emitLast));

  // R9
  emit_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !emitValid) |=> !emitValid);

endmodule

// File: rtl/crc16_byte_engine.sv
module crc16_byte_engine
  import crc16_pkg::*;
#(
  parameter int SERIAL = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        clear,
  input  logic        byteValid,
  input  logic [7:0]  byteIn,
  input  logic        emitStart,
  output logic [15:0] crcOut,
  output logic        residueZero,
  output logic        busy,
  output logic        dropFlag,
  output logic        emitValid,
  output logic [7:0]  emitByte,
  output logic        emitLast
);

  localparam int CRC_W  = 16;
  localparam int BYTE_W = 8;

  crcStrobes_t strb;

  crc16_ctrl #(.SERIAL(SERIAL), .STEPS(BYTE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .clear(clear), .byteValid(byteValid),
    .strb(strb), .busy(busy), .dropFlag(dropFlag)
  );

  crc16_datapath #(.CRC_W(CRC_W), .BYTE_W(BYTE_W), .POLY(16'hA001)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .byteIn(byteIn),
    .crcReg(crcOut), .residueZero(residueZero)
  );

  crc16_emitter #(.CRC_W(CRC_W), .BYTE_W(BYTE_W)) u_emit (
    .clk(clk), .rstN(rstN), .emitStart(emitStart), .busy(busy), .value(crcOut),
    .emitValid(emitValid), .emitByte(emitByte), .emitLast(emitLast)
  );

endmodule

// File: tb/tb_crc16_byte_engine.sv
module tb_crc16_byte_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clear = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteIn = 8'h00;
  logic        emitStart = 1'b0;

  logic [15:0] crcS, crcP;
  logic        resS, resP, busyS, busyP, dropS, dropP;
  logic        evS, evP, elS, elP;
  logic [7:0]  ebS, ebP;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] model = 16'h0000;

  always #5 clk = ~clk;

  crc16_byte_engine #(.SERIAL(1)) dut (
    .clk(clk), .rstN(rstN), .clear(clear), .byteValid(byteValid), .byteIn(byteIn),
    .emitStart(emitStart), .crcOut(crcS), .residueZero(resS), .busy(busyS),
    .dropFlag(dropS), .emitValid(evS), .emitByte(ebS), .emitLast(elS)
  );

  crc16_byte_engine #(.SERIAL(0)) dutPar (
    .clk(clk), .rstN(rstN), .clear(clear), .byteValid(byteValid), .byteIn(byteIn),
    .emitStart(emitStart), .crcOut(crcP), .residueZero(resP), .busy(busyP),
    .dropFlag(dropP), .emitValid(evP), .emitByte(ebP), .emitLast(elP)
  );

  // Vector: bit 8 = clear before the byte, bits 7:0 = byte
  localparam int NV = 12;
  localparam logic [8:0] VEC [NV] = '{
    9'h100, 9'h0FF, 9'h031, 9'h0A5,
    9'h101, 9'h080, 9'h07E,
    9'h1C3, 9'h000, 9'h055, 9'h0AA, 9'h0FF
  };

  function automatic logic [15:0] foldModel(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] t;
    t = c ^ {b, 8'h00};
    for (int i = 0; i < 8; i++) t = t[0] ? ((t >> 1) ^ 16'hA001) : (t >> 1);
    return t;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseClear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    model = 16'h0000;
  endtask

  // Offers one byte and waits until the serial variant is idle again
  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); byteValid = 1'b1; byteIn = b;
    @(negedge clk); byteValid = 1'b0;
    model = foldModel(model, b);
    chk(crcP == model, "R4 parallel ready next cycle", crcP, model);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(crcS == 16'h0 && crcP == 16'h0, "R1 reset value", crcS, 16'h0);
    chk(!busyS && resS && resP, "R1 reset busy/residue", {busyS, resS}, 2'b01);
    rstN = 1'b1;
    @(negedge clk);
    chk(!evS && !dropS, "R8 emitter idle after reset", evS, 0);

    // Vector walk: R2 and R4 for both variants
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][8]) pulseClear();
      sendByte(VEC[v][7:0]);
      chk(crcS == model, "R2 serial value", crcS, model);
      chk(crcP == crcS, "R4 variants agree", crcP, crcS);
      chk(resS == (model == 16'h0), "R7 residue flag", resS, (model == 16'h0));
    end

    // R3 busy window, and R7 residue low while stepping a zero register
    pulseClear();
    chk(resS, "R1 residue after clear", resS, 1);
    @(negedge clk); byteValid = 1'b1; byteIn = 8'h00;
    @(negedge clk); byteValid = 1'b0;
    for (int k = 0; k < 8; k++) begin
      chk(busyS, "R3 busy during steps", busyS, 1);
      chk(!resS, "R7 residue low while busy", resS, 0);
      chk(!busyP, "R4 parallel never busy", busyP, 0);
      @(negedge clk);
    end
    chk(!busyS, "R3 busy falls after eight cycles", busyS, 0);
    chk(resS && crcS == 16'h0, "R7 residue after zero byte", crcS, 0);

    // R5 byte offered while busy is dropped
    pulseClear();
    @(negedge clk); byteValid = 1'b1; byteIn = 8'h3C;
    @(negedge clk); byteIn = 8'hE7;
    @(negedge clk); byteValid = 1'b0;
    chk(dropS, "R5 drop flag pulse", dropS, 1);
    model = foldModel(16'h0, 8'h3C);
    repeat (7) @(negedge clk);
    chk(!busyS, "R5 no extra steps", busyS, 0);
    chk(crcS == model, "R5 dropped byte had no effect", crcS, model);
    chk(!dropS, "R5 drop flag one cycle", dropS, 0);

    // R6 clear beats byteValid, also mid-step
    pulseClear();
    sendByte(8'h5A);
    @(negedge clk); byteValid = 1'b1; byteIn = 8'h12;
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b1; byteValid = 1'b1; byteIn = 8'h77;
    @(negedge clk); clear = 1'b0; byteValid = 1'b0;
    chk(crcS == 16'h0 && crcP == 16'h0, "R6 clear priority", crcS, 0);
    chk(!busyS, "R6 clear ends steps", busyS, 0);
    @(negedge clk);
    chk(crcS == 16'h0 && !busyS, "R6 byte discarded", crcS, 0);
    model = 16'h0;

    // R8 emission order
    sendByte(8'hC9);
    sendByte(8'h01);
    @(negedge clk); emitStart = 1'b1;
    @(negedge clk); emitStart = 1'b0;
    chk(evS && !elS && ebS == model[15:8], "R8 high byte first", ebS, model[15:8]);
    @(negedge clk);
    chk(evS && elS && ebS == model[7:0], "R8 low byte second", ebS, model[7:0]);
    @(negedge clk);
    chk(!evS, "R8 emission ends", evS, 0);

    // R9 request while busy or emitting is ignored
    @(negedge clk); byteValid = 1'b1; byteIn = 8'h44;
    @(negedge clk); byteValid = 1'b0; emitStart = 1'b1;
    @(negedge clk); emitStart = 1'b0;
    chk(!evS, "R9 start ignored while busy", evS, 0);
    model = foldModel(model, 8'h44);
    repeat (8) @(negedge clk);
    @(negedge clk); emitStart = 1'b1;
    @(negedge clk); emitStart = 1'b1;
    chk(evS && ebS == model[15:8], "R9 first request taken", ebS, model[15:8]);
    @(negedge clk); emitStart = 1'b0;
    chk(evS && elS && ebS == model[7:0], "R9 second request ignored", ebS, model[7:0]);
    @(negedge clk);
    chk(!evS, "R9 no restart during emission", evS, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule